// File: doc/BRIEF.md
# CAN Fault-Confinement State Classifier

This block holds the transmit and receive error counts of a CAN node and derives the node's fault-confinement state from them. The four states are error-active, warning, error-passive and bus-off. The counting rules live outside the block. They deliver each new pair of counter values over a valid/ready stream. The block keeps the latest pair, presents it in one packed count word, and classifies it against fixed thresholds into a registered state.

Every change of state produces a one-cycle pulse and sets a sticky flag for the state just entered. Software clears these flags with write-one-to-clear strobes. A per-flag enable turns the flags into a single interrupt line. A restart input clears both counters and returns the node to error-active.

The update stream accepts a pair whenever `restart` is low. While `restart` is high, `upd_ready` is low, so a pair offered in that cycle is not taken. The producer must hold `upd_valid` and its data until a cycle in which `upd_ready` is high. No other back-pressure exists.

Top module: `can_fault_state`

## Requirements
- R1: After reset the count word is zero, the state is error-active (status bit 16 only), all sticky flags (status bits 3:0) are zero, and `state_chg` and `irq` are low.
- R2: A pair is taken on a clock edge where `upd_valid` and `upd_ready` are both high. From the next cycle, `cnt_word` shows the receive count in bits 7:0 and the 9-bit transmit count in bits 24:16, with all other bits zero.
- R3: The node is error-active when both counts are below 96. Exactly one of status bits 16 (active), 17 (warning), 18 (passive) and 19 (bus-off) is set at any time.
- R4: When not error-active, the node is in warning if both counts are below 128.
- R5: When neither of the above holds, the node is error-passive if the transmit count is below 256. The receive count is 8 bits and so is always below 256.
- R6: A transmit count of 256 or more gives bus-off, whatever the receive count. The precedence is bus-off, then passive, then warning, then active.
- R7: The state bits follow a change of the count word by exactly one clock cycle.
- R8: Each change of state raises `state_chg` for exactly one cycle. In the same cycle, the sticky flag of the state entered becomes set: bit 0 for active, 1 for warning, 2 for passive, 3 for bus-off.
- R9: A high bit of `evt_clr` clears the matching sticky flag at the clock edge. If a flag is being set in the same cycle, the set wins.
- R10: `irq` is high, without delay, whenever any sticky flag is set together with its bit of `irq_en`.
- R11: When `restart` is high at an edge, both counts become zero and the state becomes error-active at that edge. If the state was not already active, this counts as a change (R8). `upd_ready` is low while `restart` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | A new counter pair is offered |
| upd_ready | output | 1 | The block can take the pair this cycle |
| upd_tec | input | 9 | Offered transmit error count |
| upd_rec | input | 8 | Offered receive error count |
| restart | input | 1 | Clear counts and return to error-active |
| irq_en | input | 4 | Per-flag interrupt enables |
| evt_clr | input | 4 | Write-one-to-clear strobes for the sticky flags |
| cnt_word | output | 32 | Packed counts: receive in 7:0, transmit in 24:16 |
| status_word | output | 32 | State one-hot in 19:16, sticky flags in 3:0 |
| state_chg | output | 1 | One-cycle pulse on every state change |
| irq | output | 1 | Masked OR of the sticky flags |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a flag being set and a flag being cleared. The bench brings the node to bus-off and clears all flags. In one cycle it then raises `restart` and the clear strobe for the active flag. It judges the result by requiring the active flag to be set afterwards.

The second pair is a restart and a stream update. The bench offers a nonzero pair in the same cycle as `restart`. It checks that `upd_ready` is low then and that the count word reads zero afterwards.

// File: rtl/can_fs_pkg.sv
package can_fs_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } fs_state_e;

  localparam int NUM_STATES = 4;
  localparam int STATE_LSB  = 16;
endpackage

// File: rtl/fs_count_hold.sv
module fs_count_hold #(
  parameter int TEC_W = 9,
  parameter int REC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [TEC_W-1:0] upd_tec,
  input  logic [REC_W-1:0] upd_rec,
  input  logic             restart,
  output logic [TEC_W-1:0] tec_q,
  output logic [REC_W-1:0] rec_q
);
  assign upd_ready = !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (restart) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (upd_valid && upd_ready) begin
      tec_q <= upd_tec;
      rec_q <= upd_rec;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> (tec_q == $past(upd_tec) && rec_q == $past(upd_rec)));

  assert_restart_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tec_q == '0 && rec_q == '0));
endmodule

// File: rtl/fs_classify.sv
module fs_classify
  import can_fs_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 256
) (
  input  logic [TEC_W-1:0] tec,
  input  logic [REC_W-1:0] rec,
  output fs_state_e        cls
);
  localparam int CW = ((TEC_W > REC_W) ? TEC_W : REC_W) + 1;
  localparam logic [CW-1:0] WARN_V = CW'(WARN_LIM);
  localparam logic [CW-1:0] PASS_V = CW'(PASS_LIM);
  localparam logic [CW-1:0] BOFF_V = CW'(BOFF_LIM);

  logic [CW-1:0] tec_x, rec_x;
  logic          below_warn, below_pass, at_boff;

  assign tec_x = CW'(tec);
  assign rec_x = CW'(rec);

  assign below_warn = (tec_x < WARN_V) && (rec_x < WARN_V);
  assign below_pass = (tec_x < PASS_V) && (rec_x < PASS_V);
  assign at_boff    = (tec_x >= BOFF_V);

  always_comb begin
    if (at_boff)          cls = ST_BUSOFF;
    else if (!below_pass) cls = ST_PASSIVE;
    else if (!below_warn) cls = ST_WARN;
    else                  cls = ST_ACTIVE;
  end
endmodule

// File: rtl/fs_event_unit.sv
module fs_event_unit
  import can_fs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  fs_state_e             cls,
  input  logic                  restart,
  input  logic [NUM_STATES-1:0] evt_clr,
  input  logic [NUM_STATES-1:0] irq_en,
  output fs_state_e             state_q,
  output logic [NUM_STATES-1:0] state_oh,
  output logic [NUM_STATES-1:0] sticky_q,
  output logic                  evt_pulse,
  output logic                  irq
);
  fs_state_e next_st;
  logic      change;

  assign next_st = restart ? ST_ACTIVE : cls;
  assign change  = (next_st != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ACTIVE;
      evt_pulse <= 1'b0;
    end else begin
      state_q   <= next_st;
      evt_pulse <= change;
    end
  end

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_flag
    logic set_i;
    assign set_i       = change && (next_st == fs_state_e'(i));
    assign state_oh[i] = (state_q == fs_state_e'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sticky_q[i] <= 1'b0;
      else if (set_i)    sticky_q[i] <= 1'b1;
      else if (evt_clr[i]) sticky_q[i] <= 1'b0;
    end
  end

  assign irq = |(sticky_q & irq_en);

  assert_pulse_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> evt_pulse);

  assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> |(sticky_q & state_oh));

  assert_restart_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state_q == ST_ACTIVE));

  assert_single_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);
endmodule

// File: rtl/can_fault_state.sv
module can_fault_state
  import can_fs_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [TEC_W-1:0] upd_tec,
  input  logic [REC_W-1:0] upd_rec,
  input  logic             restart,
  input  logic [3:0]       irq_en,
  input  logic [3:0]       evt_clr,
  output logic [31:0]      cnt_word,
  output logic [31:0]      status_word,
  output logic             state_chg,
  output logic             irq
);
  localparam int TEC_LSB = 16;

  logic [TEC_W-1:0]      tec_q;
  logic [REC_W-1:0]      rec_q;
  fs_state_e             cls, state_q;
  logic [NUM_STATES-1:0] state_oh, sticky_q;

  fs_count_hold #(.TEC_W(TEC_W), .REC_W(REC_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_tec(upd_tec), .upd_rec(upd_rec), .restart(restart),
    .tec_q(tec_q), .rec_q(rec_q)
  );

  fs_classify #(.TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
                .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)) u_cls (
    .tec(tec_q), .rec(rec_q), .cls(cls)
  );

  fs_event_unit u_evt (
    .clk(clk), .rst_n(rst_n), .cls(cls), .restart(restart),
    .evt_clr(evt_clr), .irq_en(irq_en), .state_q(state_q),
    .state_oh(state_oh), .sticky_q(sticky_q), .evt_pulse(state_chg), .irq(irq)
  );

  always_comb begin
    cnt_word = '0;
    cnt_word[REC_W-1:0]       = rec_q;
    cnt_word[TEC_LSB +: TEC_W] = tec_q;
  end

  always_comb begin
    status_word = '0;
    status_word[NUM_STATES-1:0]          = sticky_q;
    status_word[STATE_LSB +: NUM_STATES] = state_oh;
  end

  assert_busoff_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(tec_q) >= 32'(BOFF_LIM)) && !restart) |=> state_oh[ST_BUSOFF]);

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);
endmodule

// File: tb/can_fault_state_tb.sv
module can_fault_state_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [8:0]  upd_tec = '0;
  logic [7:0]  upd_rec = '0;
  logic        restart = 1'b0;
  logic [3:0]  irq_en = '0;
  logic [3:0]  evt_clr = '0;
  logic [31:0] cnt_word, status_word;
  logic        state_chg, irq;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  can_fault_state u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_tec(upd_tec), .upd_rec(upd_rec), .restart(restart), .irq_en(irq_en),
    .evt_clr(evt_clr), .cnt_word(cnt_word), .status_word(status_word),
    .state_chg(state_chg), .irq(irq)
  );

  // fields: tec[18:10], rec[9:2], expected state[1:0] (0 act,1 warn,2 pass,3 boff)
  localparam int NV = 12;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {9'd0,   8'd0,   2'd0},
    {9'd95,  8'd95,  2'd0},
    {9'd96,  8'd0,   2'd1},
    {9'd0,   8'd127, 2'd1},
    {9'd50,  8'd128, 2'd2},
    {9'd127, 8'd127, 2'd1},
    {9'd128, 8'd10,  2'd2},
    {9'd255, 8'd255, 2'd2},
    {9'd256, 8'd0,   2'd3},
    {9'd300, 8'd255, 2'd3},
    {9'd511, 8'd5,   2'd3},
    {9'd0,   8'd95,  2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] t, input logic [7:0] r);
    @(negedge clk);
    upd_valid = 1'b1; upd_tec = t; upd_rec = r;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cnt", cnt_word, 32'h0);
    check("R1 status", status_word, 32'h0001_0000);
    check("R1 pulse/irq", {state_chg, irq}, 32'h0);
    check("R11 ready idle", {31'b0, upd_ready}, 32'h1);

    prev = 2'd0;
    for (int i = 0; i < NV; i++) begin
      logic [8:0] t; logic [7:0] r; logic [1:0] s;
      t = VEC[i][18:10]; r = VEC[i][9:2]; s = VEC[i][1:0];
      send(t, r);
      // R2 packed layout one cycle after the transfer edge
      check("R2 cnt_word", cnt_word, {7'b0, t, 8'b0, r});
      // R7 state not yet moved
      check("R7 lag", {28'b0, status_word[19:16]}, 32'(4'b1 << prev));
      @(negedge clk);
      // R3/R4/R5/R6 classification
      check("R3_R4_R5_R6 state", {28'b0, status_word[19:16]}, 32'(4'b1 << s));
      check("R8 pulse", {31'b0, state_chg}, {31'b0, (s != prev)});
      if (s != prev) check("R8 flag", {31'b0, status_word[s]}, 32'h1);
      @(negedge clk);
      check("R8 one cycle", {31'b0, state_chg}, 32'h0);
      prev = s;
    end

    // R9 clear all flags
    @(negedge clk); evt_clr = 4'hF;
    @(negedge clk); evt_clr = 4'h0;
    check("R9 cleared", {28'b0, status_word[3:0]}, 32'h0);

    // go to bus-off
    send(9'd260, 8'd3);
    @(negedge clk);
    check("R6 busoff", {28'b0, status_word[19:16]}, 32'h8);
    check("R8 boff flag", {28'b0, status_word[3:0]}, 32'h8);

    // R11 restart collides with update and with clear of active flag (R9 set wins)
    @(negedge clk);
    restart = 1'b1; upd_valid = 1'b1; upd_tec = 9'd100; upd_rec = 8'd40;
    evt_clr = 4'b0001;
    #1;
    check("R11 ready low", {31'b0, upd_ready}, 32'h0);
    @(negedge clk);
    restart = 1'b0; upd_valid = 1'b0; evt_clr = 4'b0;
    check("R11 cnt zero", cnt_word, 32'h0);
    check("R11 active", {28'b0, status_word[19:16]}, 32'h1);
    check("R11 pulse", {31'b0, state_chg}, 32'h1);
    check("R9 set wins", {28'b0, status_word[3:0]}, 32'h9);

    // R10 interrupt masking
    irq_en = 4'b0010; #1;
    check("R10 masked", {31'b0, irq}, 32'h0);
    irq_en = 4'b1000; #1;
    check("R10 enabled", {31'b0, irq}, 32'h1);
    @(negedge clk); evt_clr = 4'b1000;
    @(negedge clk); evt_clr = 4'b0000;
    check("R9 clear one", {28'b0, status_word[3:0]}, 32'h1);
    check("R10 after clear", {31'b0, irq}, 32'h0);
    irq_en = 4'b0001; #1;
    check("R10 active flag", {31'b0, irq}, 32'h1);

    // R11 restart while already active: no change pulse
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    check("R11 no pulse", {31'b0, state_chg}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule